// File: doc/BRIEF.md
# Vertical Free-Run Controller for AC-Driven Panels

This block keeps a liquid-crystal panel alternately driven when the incoming video loses its vertical sync. It counts line ticks since the last vertical sync. While sync keeps arriving, each sync starts a new vertical cycle. If no sync arrives within a mode-specific number of lines, the block raises a no-signal flag. It then makes its own vertical start pulses at a fixed, mode-specific line period, so the drive polarity keeps alternating.

The drive polarity output and its complement toggle either on every line or once per vertical cycle, chosen by a select input. Two mode inputs pick the timing set: a VGA-class raster, a 525-line system or a 625-line system. The block works on a line clock enable (`line_tick`), and a vertical sync pulse is only taken on a line tick.

Top module: `vfr_ctrl`

## Requirements
- R1: After reset `no_signal` and `vstart` are low, `frev` is low and `frev_n` is high.
- R2: Mode selection: `sel_vga` high picks VGA timing (loss 873 lines, free period 526). Otherwise `sel_ntsc` high picks 525-line timing (loss 291, period 269) and low picks 625-line timing (loss 339, period 321).
- R3: With `no_signal` low, `no_signal` goes high after the (loss+1)-th line tick that follows the last accepted vertical sync without another one.
- R4: The line tick that raises `no_signal` also starts a vertical cycle, so `vstart` rises with `no_signal`.
- R5: While `no_signal` is high and no sync arrives, successive `vstart` pulses rise exactly one free period of line ticks apart.
- R6: A vertical sync accepted while `no_signal` is high clears `no_signal`, starts a vertical cycle at once and restarts loss timing from that line.
- R7: `vstart` is high for exactly one line period. It rises and falls only in the cycle after a line tick.
- R8: A `vsync` pulse in a cycle without `line_tick` has no effect on any output or on loss timing.
- R9: With `inv_per_line` high, `frev` toggles after every line tick.
- R10: With `inv_per_line` low, `frev` toggles only on line ticks that start a vertical cycle.
- R11: `frev_n` is always the complement of `frev`.
- R12: An accepted vertical sync while `no_signal` is low raises `vstart` in the next cycle and restarts loss timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_tick | input | 1 | One-cycle enable per video line |
| vsync | input | 1 | Vertical sync pulse, taken only with line_tick |
| sel_vga | input | 1 | High selects VGA timing |
| sel_ntsc | input | 1 | When sel_vga is low: high 525-line, low 625-line |
| inv_per_line | input | 1 | High: polarity flips each line; low: each vertical cycle |
| vstart | output | 1 | Vertical cycle start, one line period wide |
| frev | output | 1 | Drive polarity |
| frev_n | output | 1 | Complement of frev |
| no_signal | output | 1 | Vertical sync considered lost |

## Verification
The block is first run with regular sync fields in each mode, so that locked cycles and loss of sync can be told apart. Then sync is withheld. Counting line ticks up to the flag and between free-run starts separates the three timing sets, and this is how mode decoding is checked. A stray sync without a line tick is inserted mid-gap and must leave the loss count unchanged. A sync during free run must resynchronise at once. Both inversion selects are run: per-line toggling and per-cycle toggling show different polarity patterns for the same ticks.

// File: rtl/vfr_pkg.sv
package vfr_pkg;

    typedef enum logic [1:0] {
        VMODE_625 = 2'd0,
        VMODE_525 = 2'd1,
        VMODE_VGA = 2'd2
    } vmode_e;

endpackage

// File: rtl/vfr_mode_sel.sv
module vfr_mode_sel
    import vfr_pkg::*;
#(
    parameter int LOSS_525 = 291,
    parameter int LOSS_625 = 339,
    parameter int LOSS_VGA = 873,
    parameter int PER_525  = 269,
    parameter int PER_625  = 321,
    parameter int PER_VGA  = 526,
    parameter int CW       = 10
) (
    input  logic          sel_vga,
    input  logic          sel_ntsc,
    output vmode_e        mode,
    output logic [CW-1:0] loss_lim,
    output logic [CW-1:0] per_last
);

    always_comb begin
        if (sel_vga)       mode = VMODE_VGA;
        else if (sel_ntsc) mode = VMODE_525;
        else               mode = VMODE_625;
    end

    always_comb begin
        unique case (mode)
            VMODE_VGA: begin
                loss_lim = CW'(LOSS_VGA);
                per_last = CW'(PER_VGA - 1);
            end
            VMODE_525: begin
                loss_lim = CW'(LOSS_525);
                per_last = CW'(PER_525 - 1);
            end
            default: begin
                loss_lim = CW'(LOSS_625);
                per_last = CW'(PER_625 - 1);
            end
        endcase
    end

endmodule

// File: rtl/vfr_line_timer.sv
module vfr_line_timer #(
    parameter int CW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_tick,
    input  logic          vsync,
    input  logic [CW-1:0] loss_lim,
    input  logic [CW-1:0] per_last,
    output logic          cyc_evt,
    output logic          vstart,
    output logic          no_sig
);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          nosig;
        logic          vst;
    } tim_t;

    tim_t st_q, st_d;
    logic evt_c;

    always_comb begin
        st_d  = st_q;
        evt_c = 1'b0;
        if (line_tick) begin
            if (vsync) begin
                st_d.nosig = 1'b0;
                st_d.cnt   = '0;
                evt_c      = 1'b1;
            end else if (!st_q.nosig && st_q.cnt >= loss_lim) begin
                st_d.nosig = 1'b1;
                st_d.cnt   = '0;
                evt_c      = 1'b1;
            end else if (st_q.nosig && st_q.cnt >= per_last) begin
                st_d.cnt   = '0;
                evt_c      = 1'b1;
            end else begin
                st_d.cnt   = st_q.cnt + 1'b1;
            end
            st_d.vst = evt_c;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cyc_evt = evt_c;
    assign vstart  = st_q.vst;
    assign no_sig  = st_q.nosig;

    AST_VSTART_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.vst) |-> $past(line_tick)); // R7
    AST_VSTART_FALL_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.vst) |-> $past(line_tick)); // R7
    AST_LOSS_STARTS_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.nosig) |-> st_q.vst); // R4
    AST_SYNC_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.nosig && line_tick && vsync) |=> (!st_q.nosig && st_q.vst)); // R6
    AST_NO_TICK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !line_tick |=> $stable(st_q)); // R8

endmodule

// File: rtl/vfr_invert.sv
module vfr_invert (
    input  logic clk,
    input  logic rst_n,
    input  logic line_tick,
    input  logic cyc_evt,
    input  logic per_line,
    output logic frev,
    output logic frev_n
);

    typedef struct packed {
        logic pol;
        logic pol_n;
    } inv_t;

    inv_t inv_q, inv_d;

    always_comb begin
        inv_d = inv_q;
        if (line_tick && (per_line || cyc_evt)) begin
            inv_d.pol   = ~inv_q.pol;
            inv_d.pol_n = inv_q.pol;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) inv_q <= '{pol: 1'b0, pol_n: 1'b1};
        else        inv_q <= inv_d;
    end

    assign frev   = inv_q.pol;
    assign frev_n = inv_q.pol_n;

    AST_PAIR_OPPOSITE: assert property (@(posedge clk) disable iff (!rst_n)
        inv_q.pol != inv_q.pol_n); // R11
    AST_LINE_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (line_tick && per_line) |=> (inv_q.pol != $past(inv_q.pol))); // R9
    AST_FIELD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!per_line && !cyc_evt) |=> $stable(inv_q.pol)); // R10

endmodule

// File: rtl/vfr_ctrl.sv
module vfr_ctrl
    import vfr_pkg::*;
#(
    parameter int LOSS_525 = 291,
    parameter int LOSS_625 = 339,
    parameter int LOSS_VGA = 873,
    parameter int PER_525  = 269,
    parameter int PER_625  = 321,
    parameter int PER_VGA  = 526
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_tick,
    input  logic vsync,
    input  logic sel_vga,
    input  logic sel_ntsc,
    input  logic inv_per_line,
    output logic vstart,
    output logic frev,
    output logic frev_n,
    output logic no_signal
);

    localparam int MAX_A = (LOSS_525 > LOSS_625) ? LOSS_525 : LOSS_625;
    localparam int MAX_B = (LOSS_VGA > PER_VGA) ? LOSS_VGA : PER_VGA;
    localparam int MAX_C = (PER_525 > PER_625) ? PER_525 : PER_625;
    localparam int MAX_D = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int MAX_L = (MAX_D > MAX_C) ? MAX_D : MAX_C;
    localparam int CW    = $clog2(MAX_L + 2);

    vmode_e        mode;
    logic [CW-1:0] loss_lim;
    logic [CW-1:0] per_last;
    logic          cyc_evt;

    vfr_mode_sel #(
        .LOSS_525(LOSS_525), .LOSS_625(LOSS_625), .LOSS_VGA(LOSS_VGA),
        .PER_525(PER_525), .PER_625(PER_625), .PER_VGA(PER_VGA), .CW(CW)
    ) u_mode (
        .sel_vga (sel_vga),
        .sel_ntsc(sel_ntsc),
        .mode    (mode),
        .loss_lim(loss_lim),
        .per_last(per_last)
    );

    vfr_line_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_tick(line_tick),
        .vsync    (vsync),
        .loss_lim (loss_lim),
        .per_last (per_last),
        .cyc_evt  (cyc_evt),
        .vstart   (vstart),
        .no_sig   (no_signal)
    );

    vfr_invert u_inv (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_tick(line_tick),
        .cyc_evt  (cyc_evt),
        .per_line (inv_per_line),
        .frev     (frev),
        .frev_n   (frev_n)
    );

    AST_MODE_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
        sel_vga |-> (mode == VMODE_VGA)); // R2
    AST_SYNC_STARTS_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (line_tick && vsync) |=> vstart); // R12

endmodule

// File: tb/vfr_ctrl_tb.sv
module vfr_ctrl_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line_tick = 1'b0;
    logic vsync = 1'b0;
    logic sel_vga = 1'b0;
    logic sel_ntsc = 1'b1;
    logic inv_per_line = 1'b0;
    logic vstart, frev, frev_n, no_signal;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    vfr_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .line_tick(line_tick), .vsync(vsync),
        .sel_vga(sel_vga), .sel_ntsc(sel_ntsc), .inv_per_line(inv_per_line),
        .vstart(vstart), .frev(frev), .frev_n(frev_n), .no_signal(no_signal)
    );

    // behavioural reference, advanced on each clock
    int m_cnt = 0;
    bit m_ns = 0, m_vs = 0, m_fr = 0;

    function automatic int loss_of();
        if (sel_vga) return 873;
        if (sel_ntsc) return 291;
        return 339;
    endfunction

    function automatic int per_of();
        if (sel_vga) return 526;
        if (sel_ntsc) return 269;
        return 321;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_ns = 0; m_vs = 0; m_fr = 0;
        end else if (line_tick) begin
            bit ev;
            ev = 0;
            if (vsync) begin
                m_ns = 0; m_cnt = 0; ev = 1;
            end else if (!m_ns && m_cnt >= loss_of()) begin
                m_ns = 1; m_cnt = 0; ev = 1;
            end else if (m_ns && m_cnt + 1 >= per_of()) begin
                m_cnt = 0; ev = 1;
            end else begin
                m_cnt++;
            end
            m_vs = ev;
            if (inv_per_line || ev) m_fr = !m_fr;
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R7 vstart model", vstart, m_vs);
            chk("R3 no_signal model", no_signal, m_ns);
            chk("R9/R10 frev model", frev, m_fr);
            chk("R11 frev_n complement", frev_n, !frev);
        end
    end

    task automatic tick(input logic vs);
        @(negedge clk);
        line_tick = 1'b1;
        vsync = vs;
        @(negedge clk);
        line_tick = 1'b0;
        vsync = 1'b0;
    endtask

    // ticks without sync until no_signal rises; returns count
    task automatic ticks_to_loss(output int n);
        n = 0;
        do begin
            tick(1'b0);
            n++;
        end while (!no_signal && n < 3000);
    endtask

    // ticks until next vstart rise while free-running
    task automatic ticks_to_vstart(output int n);
        n = 0;
        do begin
            tick(1'b0);
            n++;
        end while (!vstart && n < 3000);
    endtask

    task automatic mode_run(string tg, int exp_loss, int exp_per);
        int n;
        tick(1'b1);
        chk({tg, " R12 vstart after sync"}, vstart, 1);
        ticks_to_loss(n);
        chk({tg, " R2 R3 loss count"}, n, exp_loss + 1);
        chk({tg, " R4 vstart with loss"}, vstart, 1);
        tick(1'b0);
        chk({tg, " R7 vstart one line"}, vstart, 0);
        ticks_to_vstart(n);
        chk({tg, " R2 R5 free period"}, n + 1, exp_per);
        ticks_to_vstart(n);
        chk({tg, " R5 free period again"}, n, exp_per);
        tick(1'b1);
        chk({tg, " R6 flag cleared"}, no_signal, 0);
        chk({tg, " R6 vstart on resync"}, vstart, 1);
    endtask

    initial begin
        int n;
        int f0;
        repeat (3) @(negedge clk);
        checks++;
        if (vstart !== 1'b0 || no_signal !== 1'b0 || frev !== 1'b0 || frev_n !== 1'b1) begin
            errors++;
            $display("FAIL R1 reset actual %b%b%b%b expected 0001", vstart, no_signal, frev, frev_n);
        end
        rst_n = 1'b1;

        // locked 525-line fields
        for (int f = 0; f < 3; f++) begin
            tick(1'b1);
            chk("R12 locked vstart", vstart, 1);
            for (int l = 0; l < 261; l++) tick(1'b0);
            chk("R3 still locked", no_signal, 0);
        end

        sel_vga = 0; sel_ntsc = 1; mode_run("525", 291, 269);
        sel_vga = 0; sel_ntsc = 0; mode_run("625", 339, 321);
        sel_vga = 1; sel_ntsc = 0; mode_run("VGA", 873, 526);
        sel_vga = 1; sel_ntsc = 1; mode_run("VGA2", 873, 526);

        // R8: stray sync without tick mid-gap
        sel_vga = 0; sel_ntsc = 1;
        tick(1'b1);
        for (int l = 0; l < 100; l++) tick(1'b0);
        @(negedge clk); vsync = 1'b1;
        @(negedge clk); vsync = 1'b0;
        chk("R8 no vstart from stray sync", vstart, 0);
        ticks_to_loss(n);
        chk("R8 loss count unchanged", n + 100, 292);

        // R9 per-line inversion
        inv_per_line = 1'b1;
        for (int l = 0; l < 6; l++) begin
            f0 = frev;
            tick(1'b0);
            chk("R9 toggles each line", frev, !f0);
        end
        // R10 field inversion: hold between starts
        inv_per_line = 1'b0;
        tick(1'b1);
        f0 = frev;
        for (int l = 0; l < 20; l++) tick(1'b0);
        chk("R10 held within field", frev, f0);
        tick(1'b1);
        chk("R10 toggles at start", frev, !f0);

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule